// File: doc/BRIEF.md
# SD Card Clock Control Unit

This block holds the clock-control register of an SD host controller and turns the base clock into the card clock. Software writes a 16-bit control word. The word carries an 8-bit frequency-select field, an internal-clock enable and a card-clock enable. The block reports an internal-clock-stable flag in the same word. It also produces the card clock as a registered level, together with a one-cycle clock-enable strobe that marks the first base cycle of each card-clock period.

A field value N of 1 or more divides the base clock by 2N. A value of 0 lets the base clock through: the strobe is then high on every cycle and the level is held high. For a base clock near 96 MHz, field values from 1 to 128 cover the usual range, from about 375 kHz for card identification up to 48 MHz.

Software brings the clock up in order:
1. Write zero.
2. Write the divisor with the internal enable set.
3. Poll the stable flag.
4. Set the card-clock enable.

A separate request pulse starts a self-clearing reset of the register. A busy output reports that reset while it is in progress.

Top module: `sdclk_unit`

## Requirements
- R1: After hardware reset the readback word is 0x0000, the card-clock level and strobe are low, and reset-busy is low.
- R2: A write stores the divisor from bits 15:8, the internal enable from bit 0 and the card-clock enable from bit 2. The readback returns these bits in the same positions. Bit 1 shows only the stable flag, and written values there have no effect. Bits 7:3, and any divisor bits above the configured width, read as zero.
- R3: The stable flag (bit 1) rises exactly STABLE_DELAY base cycles after the write that sets the internal enable. It clears on the same edge that clears the internal enable.
- R4: The card clock runs only while the internal enable, the stable flag and the card-clock enable are all set. Otherwise both the strobe and the level stay low. The first strobe appears in the second cycle after the run condition becomes true.
- R5: With field N ≥ 1 each card period lasts 2N base cycles. The level is high for the first N cycles and low for the last N, and the strobe is high only in the first cycle.
- R6: With field 0 the strobe is high in every cycle and the level stays high.
- R7: A new divisor takes effect only at the end of the current low phase. A period already started completes with the old divisor.
- R8: Clearing the card-clock enable or the internal enable forces the strobe and the level low by the second cycle after the write.
- R9: A reset request clears the whole register at once. Reset-busy then stays high for RESET_CYCLES cycles and clears by itself, after which writes take effect again.
- R10: Writes made while reset-busy is high are ignored: the register reads zero and the card clock stays stopped once busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low hardware reset |
| wrEn | input | 1 | Control-word write strobe |
| wrData | input | 16 | Control word to write |
| swRstReq | input | 1 | One-cycle request for the self-clearing register reset |
| ctrlRd | output | 16 | Control-word readback including the stable flag |
| resetBusy | output | 1 | High while the register reset is in progress |
| cardClk | output | 1 | Registered card-clock level |
| cardClkTick | output | 1 | Clock-enable strobe on the first base cycle of each card period |

## Verification
The bench builds the unit with a 4-bit divisor field, a stable delay of 5 cycles and a reset length of 4 cycles. With these values every divisor setting, 0 through 15, can be swept. For each setting the bench checks three whole card periods cycle by cycle against the 2N rule. The short delays also let the bench pin down the exact edge on which the stable flag, the first strobe and the end of busy appear. A divisor change is written during the high phase, and the bench checks the whole old period followed by the whole new one.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  localparam int REG_W      = 16;
  localparam int INT_EN_BIT = 0;
  localparam int STABLE_BIT = 1;
  localparam int SD_EN_BIT  = 2;
  localparam int DIV_LSB    = 8;
  localparam int DIV_MAX_W  = REG_W - DIV_LSB;

  // strobes from control to the divider datapath
  typedef struct packed {
    logic run;      // all enables and stable set
    logic restart;  // register reset accepted this cycle
  } clkStrobe_t;

endpackage

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int STABLE_DELAY = 16,
  parameter int RESET_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic              swRstReq,
  output logic [REG_W-1:0]  ctrlRd,
  output logic              resetBusy,
  output logic [DIV_W-1:0]  divField,
  output clkStrobe_t        strobe
);

  localparam int ST_W = $clog2(STABLE_DELAY + 1);
  localparam int RS_W = $clog2(RESET_CYCLES + 1);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(STABLE_DELAY - 1);
  localparam logic [RS_W-1:0] RS_LAST = RS_W'(RESET_CYCLES - 1);

  logic [DIV_W-1:0] divQ;
  logic             intEnQ;
  logic             sdEnQ;
  logic             stableQ;
  logic [ST_W-1:0]  stCnt;
  logic             busyQ;
  logic [RS_W-1:0]  rsCnt;
  logic             intEnNext;
  logic             resetAccept;

  assign resetAccept = swRstReq && !busyQ;
  assign intEnNext   = wrEn ? wrData[INT_EN_BIT] : intEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ    <= '0;
      intEnQ  <= 1'b0;
      sdEnQ   <= 1'b0;
      stableQ <= 1'b0;
      stCnt   <= '0;
      busyQ   <= 1'b0;
      rsCnt   <= '0;
    end else if (busyQ) begin
      // register held at zero, writes dropped
      divQ    <= '0;
      intEnQ  <= 1'b0;
      sdEnQ   <= 1'b0;
      stableQ <= 1'b0;
      stCnt   <= '0;
      if (rsCnt == RS_LAST) begin
        busyQ <= 1'b0;
        rsCnt <= '0;
      end else begin
        rsCnt <= rsCnt + 1'b1;
      end
    end else if (resetAccept) begin
      divQ    <= '0;
      intEnQ  <= 1'b0;
      sdEnQ   <= 1'b0;
      stableQ <= 1'b0;
      stCnt   <= '0;
      busyQ   <= 1'b1;
      rsCnt   <= '0;
    end else begin
      if (wrEn) begin
        divQ   <= wrData[DIV_LSB +: DIV_W];
        intEnQ <= wrData[INT_EN_BIT];
        sdEnQ  <= wrData[SD_EN_BIT];
      end
      if (!intEnNext) begin
        stableQ <= 1'b0;
        stCnt   <= '0;
      end else if (intEnQ && !stableQ) begin
        if (stCnt == ST_LAST) begin
          stableQ <= 1'b1;
        end else begin
          stCnt <= stCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctrlRd                   = '0;
    ctrlRd[DIV_LSB +: DIV_W] = divQ;
    ctrlRd[SD_EN_BIT]        = sdEnQ;
    ctrlRd[STABLE_BIT]       = stableQ;
    ctrlRd[INT_EN_BIT]       = intEnQ;
  end

  assign resetBusy      = busyQ;
  assign divField       = divQ;
  assign strobe.run     = intEnQ && stableQ && sdEnQ;
  assign strobe.restart = resetAccept;

  // R3: stable only rises after the internal enable has been held
  assert_stable_after_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stableQ) |-> (intEnQ && $past(intEnQ)));

  // R9: the register is zero throughout the reset
  assert_busy_clears_reg_R9: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (divQ == '0 && !intEnQ && !sdEnQ && !stableQ));

  // R10: writes during reset leave the register untouched
  assert_busy_ignores_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ)) |-> $stable({divQ, intEnQ, sdEnQ}));

  // R9: busy always clears before a new request can be accepted
  assert_reset_self_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busyQ)) |-> $past(rsCnt) == RS_LAST);

endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  clkStrobe_t       strobe,
  input  logic [DIV_W-1:0] divField,
  output logic             cardClk,
  output logic             cardClkTick
);

  localparam int CNT_W = DIV_W + 1;

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] activeDiv;
  logic             levelQ;
  logic             tickQ;

  logic             runNext;
  logic [CNT_W-1:0] cntNext;
  logic [DIV_W-1:0] divNext;
  logic [CNT_W-1:0] lastCnt;
  logic             levelNext;
  logic             tickNext;

  assign lastCnt = {activeDiv, 1'b0} - 1'b1;

  always_comb begin
    runNext = strobe.run && !strobe.restart;
    cntNext = cnt + 1'b1;
    divNext = activeDiv;
    if (!runNext || !running) begin
      cntNext = '0;
      divNext = divField;
    end else if (activeDiv == '0 || cnt == lastCnt) begin
      // end of the low phase: only point where the divisor may change
      cntNext = '0;
      divNext = divField;
    end
    levelNext = runNext && (divNext == '0 || cntNext < {1'b0, divNext});
    tickNext  = runNext && (cntNext == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      cnt       <= '0;
      activeDiv <= '0;
      levelQ    <= 1'b0;
      tickQ     <= 1'b0;
    end else begin
      running   <= runNext;
      cnt       <= cntNext;
      activeDiv <= divNext;
      levelQ    <= levelNext;
      tickQ     <= tickNext;
    end
  end

  assign cardClk     = levelQ;
  assign cardClkTick = tickQ;

  // R4: no card clock activity after a cycle without the run strobe
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.run) |-> (!cardClkTick && !cardClk));

  // R6: bypass setting keeps strobe and level high
  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rstN)
    (running && activeDiv == '0) |-> (cardClkTick && cardClk));

  // R7: the divisor in use changes only at the start of a period
  assert_reload_at_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && activeDiv != $past(activeDiv)) |-> cnt == '0);

  // R5: while running, the level falls exactly at the half period
  assert_half_period_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cardClk) && running && activeDiv != '0) |-> cnt == {1'b0, activeDiv});

endmodule

// File: rtl/sdclk_unit.sv
module sdclk_unit
  import sdclk_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int STABLE_DELAY = 16,
  parameter int RESET_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        swRstReq,
  output logic [15:0] ctrlRd,
  output logic        resetBusy,
  output logic        cardClk,
  output logic        cardClkTick
);

  clkStrobe_t       strobe;
  logic [DIV_W-1:0] divField;

  sdclk_ctrl #(
    .DIV_W       (DIV_W),
    .STABLE_DELAY(STABLE_DELAY),
    .RESET_CYCLES(RESET_CYCLES)
  ) ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .swRstReq (swRstReq),
    .ctrlRd   (ctrlRd),
    .resetBusy(resetBusy),
    .divField (divField),
    .strobe   (strobe)
  );

  sdclk_div #(
    .DIV_W(DIV_W)
  ) divInst (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .divField   (divField),
    .cardClk    (cardClk),
    .cardClkTick(cardClkTick)
  );

  initial begin
    assert_div_width_fits: assert (DIV_W >= 1 && DIV_W <= DIV_MAX_W);
  end

endmodule

// File: tb/sdclk_unit_test.sv
module sdclk_unit_test;

  localparam int DW = 4;
  localparam int SD = 5;
  localparam int RC = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        swRstReq = 1'b0;
  logic [15:0] ctrlRd;
  logic        resetBusy;
  logic        cardClk;
  logic        cardClkTick;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sdclk_unit #(.DIV_W(DW), .STABLE_DELAY(SD), .RESET_CYCLES(RC)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .swRstReq(swRstReq),
    .ctrlRd(ctrlRd), .resetBusy(resetBusy), .cardClk(cardClk), .cardClkTick(cardClkTick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns one negedge later
  task automatic writeCtrl(input logic [15:0] v);
    wrEn = 1'b1;
    wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic requestReset();
    swRstReq = 1'b1;
    @(negedge clk);
    swRstReq = 1'b0;
  endtask

  task automatic waitStable();
    for (int g = 0; g < 100 && !ctrlRd[1]; g++) @(negedge clk);
  endtask

  task automatic waitTick();
    for (int g = 0; g < 100 && !cardClkTick; g++) @(negedge clk);
  endtask

  initial begin
    int seen;
    int errs;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ctrlRd == 16'h0000, "R1 readback", ctrlRd, 0);
    check(!cardClk && !cardClkTick, "R1 clock quiet", cardClk, 0);
    check(!resetBusy, "R1 busy", resetBusy, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 field positions, read-only and reserved bits
    writeCtrl(16'hFFFF);
    check(ctrlRd == 16'h0F05, "R2 all-ones write", ctrlRd, 16'h0F05);
    writeCtrl(16'h0000);
    check(ctrlRd == 16'h0000, "R2 zero write", ctrlRd, 0);

    // R3 stable timing
    writeCtrl(16'h0301);
    repeat (SD - 1) @(negedge clk);
    check(!ctrlRd[1], "R3 not yet stable", ctrlRd[1], 0);
    @(negedge clk);
    check(ctrlRd[1], "R3 stable after delay", ctrlRd[1], 1);
    writeCtrl(16'h0300);
    check(!ctrlRd[1], "R3 stable drops with enable", ctrlRd[1], 0);

    // R4 card enable set before stable
    writeCtrl(16'h0105);
    seen = 0;
    for (int i = 1; i <= SD + 1; i++) begin
      if (cardClkTick || cardClk) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R4 no clock before stable", seen, 0);
    check(cardClkTick, "R4 first strobe timing", cardClkTick, 1);
    // R4 card enable without internal enable
    writeCtrl(16'h0000);
    writeCtrl(16'h0104);
    seen = 0;
    for (int i = 0; i < 3 * SD; i++) begin
      if (cardClkTick || cardClk) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R4 no clock without internal enable", seen, 0);

    // R5 / R6 sweep of every divisor value
    for (int n = 0; n < (1 << DW); n++) begin
      int p;
      p = (n == 0) ? 1 : 2 * n;
      writeCtrl(16'h0000);
      writeCtrl(16'(n << 8) | 16'h0001);
      waitStable();
      writeCtrl(16'(n << 8) | 16'h0005);
      check(!cardClkTick, "R4 strobe not in first cycle", cardClkTick, 0);
      @(negedge clk);
      check(cardClkTick, "R4 strobe in second cycle", cardClkTick, 1);
      errs = 0;
      for (int i = 0; i < 3 * p; i++) begin
        bit expL;
        bit expT;
        expL = (n == 0) || ((i % p) < n);
        expT = (i % p) == 0;
        if (cardClk !== expL || cardClkTick !== expT) errs++;
        @(negedge clk);
      end
      if (n == 0) check(errs == 0, "R6 bypass pattern", errs, 0);
      else        check(errs == 0, "R5 divide-by-2N pattern", errs, 0);
    end

    // R7 divisor change during the high phase
    writeCtrl(16'h0000);
    writeCtrl(16'h0201);
    waitStable();
    writeCtrl(16'h0205);
    waitTick();
    errs = 0;
    wrEn = 1'b1;
    wrData = 16'h0505;
    for (int i = 0; i < 14; i++) begin
      bit expL;
      bit expT;
      expL = (i < 2) || (i >= 4 && i < 9);
      expT = (i == 0) || (i == 4);
      if (cardClk !== expL || cardClkTick !== expT) errs++;
      @(negedge clk);
      wrEn = 1'b0;
      wrData = '0;
    end
    check(errs == 0, "R7 old period completes then new divisor", errs, 0);

    // R8 stop by clearing card enable
    writeCtrl(16'h0501);
    @(negedge clk);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      if (cardClkTick || cardClk) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R8 stop on card enable clear", seen, 0);
    // R8 stop by clearing internal enable
    writeCtrl(16'h0505);
    waitTick();
    writeCtrl(16'h0504);
    @(negedge clk);
    check(!cardClkTick && !cardClk, "R8 stop on internal enable clear", cardClk, 0);
    check(!ctrlRd[1], "R8 stable cleared", ctrlRd[1], 0);

    // R9 / R10 register reset
    writeCtrl(16'h0201);
    waitStable();
    writeCtrl(16'h0205);
    repeat (3) @(negedge clk);
    requestReset();
    check(ctrlRd == 16'h0000 && resetBusy, "R9 cleared and busy", ctrlRd, 0);
    writeCtrl(16'h0305);
    repeat (RC - 2) @(negedge clk);
    check(resetBusy, "R9 busy through last cycle", resetBusy, 1);
    @(negedge clk);
    check(!resetBusy, "R9 busy self-clears", resetBusy, 0);
    check(ctrlRd == 16'h0000, "R10 write during busy ignored", ctrlRd, 0);
    check(!cardClkTick && !cardClk, "R10 clock stays stopped", cardClk, 0);
    writeCtrl(16'h0101);
    check(ctrlRd == 16'h0101, "R9 writes accepted after busy", ctrlRd, 16'h0101);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule